// File: doc/BRIEF.md
# Fall-Through FIFO with Strobe Handshake

This block is a clocked first-in first-out buffer of the fall-through kind. A producer raises a shift-in strobe to hand over one word and watches an input-ready flag. A consumer watches an output-ready flag and raises a shift-out strobe to take the word shown on the data outputs. Once a word has been accepted it moves on its own to the output register after a fixed number of clock cycles. No read command is needed to bring it forward.

The block keeps to strict flag sequencing. Output-ready always drops before the output data changes. When the buffer runs dry, the last word stays on the outputs, marked invalid. If shift-out is held high while the buffer is empty, a newly arriving word shows up, flags valid for exactly one cycle and is taken. An active-low master reset clears everything. What happens after reset is released depends on the level of shift-in at that moment.

Top module: `strobe_fifo`

## Requirements
- R1: While `mrN` is low, `dataOut` is all zeros, `inReady` is 1 and `outReady` is 0.
- R2: A rising edge of `shiftIn` (sampled on `clk`) while `inReady` is 1 stores `dataIn`. `inReady` is 0 from the next clock edge on. It returns to 1 only after `shiftIn` is sampled low and the memory is not full.
- R3: If `shiftIn` is high when `mrN` is released, `dataIn` is stored at the first clock edge, and `inReady` stays 0 until `shiftIn` goes low. If `shiftIn` is low at release, `inReady` stays 1 and nothing is stored until `shiftIn` rises.
- R4: With an empty output and `shiftOut` low, a word stored at clock edge n is on `dataOut` from edge n+LATENCY (default 2), and `outReady` rises one edge later.
- R5: Words leave in the order they were stored.
- R6: A sampled `shiftOut` of 1 while `outReady` is 1 removes the word, and `outReady` is 0 after that edge. `dataOut` never changes at an edge where `outReady` was 1 before the edge.
- R7: When no stored word remains, `dataOut` keeps the last word and `outReady` stays 0.
- R8: If `shiftOut` is held high while the output is empty, the next word arrives on `dataOut`. `outReady` is then 1 for exactly one cycle and the word stays on `dataOut`. Later words wait until `shiftOut` is low.
- R9: A `shiftOut` pulse while `outReady` is 0 and the output is empty has no effect on `dataOut` or on later words.
- R10: The memory holds DEPTH words besides the word at the output. `inReady` is 0 while the memory is full, and a `shiftIn` rise while `inReady` is 0 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrN | input | 1 | Master reset, active low, asynchronous assert |
| shiftIn | input | 1 | Shift-in strobe, acted on at its rising edge |
| dataIn | input | WIDTH | Word to store |
| inReady | output | 1 | Input-ready flag |
| shiftOut | input | 1 | Shift-out strobe |
| outReady | output | 1 | Output-ready flag; 1 means `dataOut` is valid and stable |
| dataOut | output | WIDTH | Output word register |

## Verification
A corrupted word count or pointer shows at the ports as a wrong, repeated or missing word. The scoreboard catches it at the next rise of `outReady`, which comes LATENCY+1 cycles after a write into an empty output. A stuck drain-wait or flag state shows as an `outReady` pulse that is too long or missing, or as data changing while `outReady` is high. The bench checks these on every cycle, not only at the tests' explicit sample points. Reset release is exercised with `shiftIn` both high and low, because a wrong edge-detector reset value shows up only in the first cycle after release.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic write;  // store dataIn at the write pointer
    logic load;   // move the head word into the output register
  } ftStrobe_t;
endpackage

// File: rtl/strobe_fifo_dp.sv
module strobe_fifo_dp
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             mrN,
  input  ftStrobe_t        strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // Storage array; a loaded word was written at least one edge earlier.
  always_ff @(posedge clk) begin
    if (strb.write) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      dataOut <= '0;
    end else begin
      if (strb.write) wrPtr <= bump(wrPtr);
      if (strb.load) begin
        dataOut <= mem[rdPtr];
        rdPtr   <= bump(rdPtr);
      end
    end
  end

  AST_NO_SIMULTANEOUS_SAME_SLOT: assert property (@(posedge clk) disable iff (!mrN)
    (strb.write && strb.load) |-> (wrPtr != rdPtr)) else $error("same slot");  // R5
endmodule

// File: rtl/strobe_fifo_ctl.sv
module strobe_fifo_ctl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LATENCY = 2
) (
  input  logic      clk,
  input  logic      mrN,
  input  logic      shiftIn,
  input  logic      shiftOut,
  output ftStrobe_t strb,
  output logic      inReady,
  output logic      outReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             siPrev;
  logic             outValid;
  logic             drainWait;
  logic [CNT_W-1:0] memCount;
  logic [CNT_W-1:0] readyCount;
  logic             wrAcc, loadNow, consume, full, landed;

  assign full    = (memCount == CNT_W'(DEPTH));
  assign wrAcc   = shiftIn && !siPrev && inReady;
  assign loadNow = !outValid && (readyCount != '0) && !drainWait;
  assign consume = outReady && shiftOut;
  assign strb.write = wrAcc;
  assign strb.load  = loadNow;

  // Fall-through delay: a stored word becomes loadable LATENCY-1 edges later.
  generate
    if (LATENCY <= 1) begin : g_direct
      assign landed = wrAcc;
    end else begin : g_pipe
      logic [LATENCY-2:0] ftPipe;
      always_ff @(posedge clk or negedge mrN) begin
        if (!mrN) ftPipe <= '0;
        else begin
          ftPipe[0] <= wrAcc;
          for (int i = 1; i < LATENCY - 1; i++) ftPipe[i] <= ftPipe[i-1];
        end
      end
      assign landed = ftPipe[LATENCY-2];
    end
  endgenerate

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      siPrev     <= 1'b0;
      inReady    <= 1'b1;
      outReady   <= 1'b0;
      outValid   <= 1'b0;
      drainWait  <= 1'b0;
      memCount   <= '0;
      readyCount <= '0;
    end else begin
      siPrev     <= shiftIn;
      memCount   <= memCount + CNT_W'(wrAcc) - CNT_W'(loadNow);
      readyCount <= readyCount + CNT_W'(landed) - CNT_W'(loadNow);

      if (wrAcc)         inReady <= 1'b0;
      else if (full)     inReady <= 1'b0;
      else if (!shiftIn) inReady <= 1'b1;

      if (loadNow)      outValid <= 1'b1;
      else if (consume) outValid <= 1'b0;

      // Valid flag follows the output register by one edge, so it is
      // low in the cycle the data changes.
      outReady <= consume ? 1'b0 : outValid;

      if (consume)        drainWait <= 1'b1;
      else if (!shiftOut) drainWait <= 1'b0;
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!mrN)
    full |-> !strb.write) else $error("write while full");  // R10
  AST_IR_DROPS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!mrN)
    strb.write |=> !inReady) else $error("IR stayed high");  // R2
  AST_OR_FALLS_ON_TAKE: assert property (@(posedge clk) disable iff (!mrN)
    (outReady && shiftOut) |=> !outReady) else $error("OR held");  // R8
  AST_LOAD_ONLY_WHEN_OR_LOW: assert property (@(posedge clk) disable iff (!mrN)
    strb.load |-> !outReady) else $error("load under OR");  // R6
  AST_READY_WITHIN_STORED: assert property (@(posedge clk) disable iff (!mrN)
    readyCount <= memCount) else $error("count skew");  // R5
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int DEPTH   = 64,
  parameter int LATENCY = 2
) (
  input  logic             clk,
  input  logic             mrN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  output logic [WIDTH-1:0] dataOut
);
  ftStrobe_t strb;

  strobe_fifo_ctl #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_ctl (
    .clk(clk), .mrN(mrN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .strb(strb), .inReady(inReady), .outReady(outReady)
  );

  strobe_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .mrN(mrN), .strb(strb), .dataIn(dataIn), .dataOut(dataOut)
  );

  AST_OR_LOW_BEFORE_CHANGE: assert property (@(posedge clk) disable iff (!mrN)
    !$stable(dataOut) |-> !$past(outReady)) else $error("data moved under OR");  // R6
endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int W = 4;
  localparam int D = 64;

  logic clk = 1'b0, mrN = 1'b1, shiftIn = 1'b0, shiftOut = 1'b0;
  logic [W-1:0] dataIn = '0, dataOut;
  logic inReady, outReady;
  logic [W-1:0] expQ[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  strobe_fifo #(.WIDTH(W), .DEPTH(D), .LATENCY(2)) i_strobe_fifo (
    .clk(clk), .mrN(mrN), .shiftIn(shiftIn), .dataIn(dataIn), .inReady(inReady),
    .shiftOut(shiftOut), .outReady(outReady), .dataOut(dataOut)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every rise of outReady and watches R6.
  logic prevOr = 1'b0;
  logic [W-1:0] prevData = '0;
  always @(negedge clk) begin
    if (!mrN) begin
      prevOr = 1'b0;
      prevData = dataOut;
    end else begin
      if (dataOut !== prevData && prevOr)
        check(1'b0, "R6", "data changed while OR high", dataOut, prevData);
      if (outReady && !prevOr) begin
        if (expQ.size() == 0) check(1'b0, "R5", "unexpected word", dataOut, 0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(dataOut == e, "R5", "word order", dataOut, e);
        end
      end
      prevOr = outReady;
      prevData = dataOut;
    end
  end

  task automatic pushWord(input logic [W-1:0] w, input bit irBack);
    @(negedge clk); shiftIn = 1'b1; dataIn = w; expQ.push_back(w);
    @(negedge clk); check(inReady == 1'b0, "R2", "IR after write", inReady, 0);
    shiftIn = 1'b0;
    @(negedge clk);
    if (irBack) check(inReady == 1'b1, "R2", "IR after SI low", inReady, 1);
  endtask

  task automatic waitOr();
    int n = 0;
    while (!outReady && n < 60) begin @(negedge clk); n++; end
    check(outReady == 1'b1, "R4", "OR eventually high", outReady, 1);
  endtask

  task automatic popWord();
    waitOr();
    shiftOut = 1'b1;
    @(negedge clk); shiftOut = 1'b0;
    check(outReady == 1'b0, "R6", "OR low after take", outReady, 0);
  endtask

  task automatic masterReset(input logic siLevel);
    @(negedge clk); mrN = 1'b0; shiftIn = siLevel; shiftOut = 1'b0;
    expQ.delete();
    repeat (2) @(negedge clk);
    check(dataOut == '0, "R1", "data in reset", dataOut, 0);
    check(inReady == 1'b1, "R1", "IR in reset", inReady, 1);
    check(outReady == 1'b0, "R1", "OR in reset", outReady, 0);
    mrN = 1'b1;
  endtask

  initial begin
    #1 mrN = 1'b0;
    // Release with SI low: nothing stored
    masterReset(1'b0);
    dataIn = 4'h3;
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R3", "IR high after low-SI release", inReady, 1);
    check(outReady == 1'b0, "R3", "nothing stored after low-SI release", outReady, 0);

    // Fall-through latency
    pushWord(4'hA, 1'b1);
    check(dataOut == 4'h0, "R4", "data before latency", dataOut, 0);
    @(negedge clk);
    check(dataOut == 4'hA, "R4", "data at edge n+2", dataOut, 4'hA);
    check(outReady == 1'b0, "R4", "OR low with new data", outReady, 0);
    @(negedge clk);
    check(outReady == 1'b1, "R4", "OR one edge later", outReady, 1);
    popWord();

    // Empty hold
    repeat (5) @(negedge clk);
    check(dataOut == 4'hA, "R7", "last word held", dataOut, 4'hA);
    check(outReady == 1'b0, "R7", "OR low when empty", outReady, 0);

    // Shift-out while empty is ignored
    @(negedge clk); shiftOut = 1'b1;
    @(negedge clk); shiftOut = 1'b0;
    repeat (3) @(negedge clk);
    check(dataOut == 4'hA, "R9", "data after idle SO", dataOut, 4'hA);
    pushWord(4'h5, 1'b1);
    waitOr();
    check(dataOut == 4'h5, "R9", "next word intact", dataOut, 4'h5);
    popWord();

    // Ordering over a burst
    for (int i = 0; i < 6; i++) pushWord(W'(i * 7 + 1), 1'b1);
    for (int i = 0; i < 6; i++) popWord();

    // Held shift-out into an empty FIFO
    repeat (3) @(negedge clk);
    shiftOut = 1'b1;
    pushWord(4'hC, 1'b1);
    waitOr();
    @(negedge clk);
    check(outReady == 1'b0, "R8", "OR pulse one cycle", outReady, 0);
    check(dataOut == 4'hC, "R8", "word stays", dataOut, 4'hC);
    pushWord(4'h6, 1'b1);
    repeat (4) @(negedge clk);
    check(dataOut == 4'hC, "R8", "later word waits", dataOut, 4'hC);
    check(outReady == 1'b0, "R8", "OR low while held", outReady, 0);
    shiftOut = 1'b0;
    waitOr();
    check(dataOut == 4'h6, "R8", "later word after SO low", dataOut, 4'h6);
    popWord();

    // Fill: DEPTH in memory plus one at the output
    for (int i = 0; i <= D; i++) pushWord(W'(i * 5 + 2), i < D);
    check(inReady == 1'b0, "R10", "IR low when full", inReady, 0);
    @(negedge clk); shiftIn = 1'b1; dataIn = 4'hF;
    @(negedge clk); shiftIn = 1'b0;
    @(negedge clk);
    check(inReady == 1'b0, "R10", "IR stays low while full", inReady, 0);
    for (int i = 0; i <= D; i++) popWord();
    repeat (6) @(negedge clk);
    check(outReady == 1'b0, "R10", "no extra word", outReady, 0);
    check(expQ.size() == 0, "R10", "scoreboard drained", expQ.size(), 0);

    // Release with SI high: immediate write
    masterReset(1'b1);
    dataIn = 4'h9;
    expQ.push_back(4'h9);
    @(negedge clk);
    check(inReady == 1'b0, "R3", "IR low after high-SI release", inReady, 0);
    repeat (2) @(negedge clk);
    check(inReady == 1'b0, "R3", "IR low while SI high", inReady, 0);
    shiftIn = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R3", "IR back after SI low", inReady, 1);
    waitOr();
    check(dataOut == 4'h9, "R3", "word stored at release", dataOut, 4'h9);
    popWord();
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5", "all words seen", expQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule